// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Component

This block evaluates one short FIR polyphase component: the dot product of `TAPS` signed input samples with fixed signed coefficients. It uses no multiplier. The samples arrive in parallel from a tap delay line and are loaded when a start pulse is accepted. The block then walks through the sample bits one per clock, least significant bit first. On each clock, the bits taken from all taps at the current position form an address into a coefficient table. The table value read at that address is merged into an accumulator that is halved on each step. At the most significant bit position the table value is subtracted instead of added.

The coefficient table is computed at elaboration from the coefficient parameter. The `CODING` parameter selects one of two table forms:
- **Plain two's-complement:** the table has 2^TAPS entries, and the accumulator starts at zero.
- **Offset-binary:** the table has half as many entries, and a table value is negated when the top tap's bit is 0. A constant equal to minus the coefficient sum, scaled by 2^DW, is preloaded into the accumulator before each computation. The final sum is halved to give the result.

Each computation takes `DW` clocks. The result register holds the last product until the next one is done.

Top module: `dafir_fir`

## Requirements
- R1: While reset is held, and after it is released with no start accepted, `done_o` is 0 and `result_o` is 0.
- R2: The tap word for tap k sits in `taps_i[k*DW +: DW]` as DW-bit two's complement. Coefficient k sits in `COEFS[k*CW +: CW]` as CW-bit two's complement. For any tap words, `result_o` equals the exact integer sum over k of coef_k * tap_k.
- R3: The result is exact at the range extremes: all taps at the most negative value, all taps at the most positive value, all taps zero, and a mix of extremes.
- R4: Call the clock edge that accepts a start edge 0. `done_o` is 1 for exactly one cycle, after edge DW, and `result_o` is valid in that cycle. `done_o` is 0 in the cycles between edge 0 and edge DW.
- R5: A start pulse that arrives while a computation is running, other than in its final bit cycle, is ignored. The running result and its completion time are unchanged, and no extra `done_o` follows.
- R6: A start held during the final bit cycle of a computation is accepted on that edge. Back-to-back computations therefore deliver one result every DW clocks.
- R7: `result_o` holds its value in every cycle in which `done_o` is 0.
- R8: The plain two's-complement coding and the halved offset-binary coding with initial-condition preload produce identical results for the same inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to load `taps_i` and begin a computation |
| taps_i | input | TAPS*DW | Parallel tap words, tap k at bits [k*DW +: DW] |
| result_o | output | RW | Signed dot product of the last finished computation |
| done_o | output | 1 | One-cycle strobe: `result_o` has just been updated |

## Verification
Each result is due DW clock edges after the edge that accepted its start. There is one edge to load the shift registers, and DW-1 more edges before the sign-bit edge writes the result register. The bench drives inputs on falling edges and counts rising edges from the accepting edge. It checks at the falling edge after edge DW-1 that `done_o` is still low. It then checks `done_o` and `result_o` at the falling edge after edge DW. For the back-to-back and ignored-start cases, the same count is restarted from the edge on which the second start is or is not accepted.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

    // Table form chosen at elaboration
    typedef enum logic {
        CODE_TWOS   = 1'b0,   // full 2^TAPS table, zero preload
        CODE_OFFSET = 1'b1    // half table, odd-symmetry negation, constant preload
    } da_code_e;

endpackage

// File: rtl/dafir_seq.sv
// Bit-cycle sequencer: one counter, start acceptance, sign-bit strobe
module dafir_seq #(
    parameter int DW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic busy_o,
    output logic sign_o
);
    localparam int CNTW = (DW > 2) ? $clog2(DW) : 1;

    typedef struct packed {
        logic            busy;
        logic [CNTW-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;
    logic last_bit;
    logic accept;

    always_comb begin
        last_bit = s_q.busy && (s_q.cnt == CNTW'(DW - 1));
        accept   = start_i && (!s_q.busy || last_bit);
        s_d      = s_q;
        if (accept) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
        end else if (last_bit) begin
            s_d.busy = 1'b0;
            s_d.cnt  = '0;
        end else if (s_q.busy) begin
            s_d.cnt  = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign load_o = accept;
    assign busy_o = s_q.busy;
    assign sign_o = last_bit;
endmodule

// File: rtl/dafir_bits.sv
// Parallel-load shift registers, one per tap, emitting the LSB first
module dafir_bits #(
    parameter int TAPS = 4,
    parameter int DW   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               shift_i,
    input  logic [TAPS*DW-1:0] taps_i,
    output logic [TAPS-1:0]    bits_o
);
    logic [DW-1:0] sr_d [TAPS];
    logic [DW-1:0] sr_q [TAPS];

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        always_comb begin
            sr_d[k] = sr_q[k];
            if (load_i)       sr_d[k] = taps_i[k*DW +: DW];
            else if (shift_i) sr_d[k] = {sr_q[k][DW-1], sr_q[k][DW-1:1]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr_q[k] <= '0;
            else        sr_q[k] <= sr_d[k];
        end

        assign bits_o[k] = sr_q[k][0];
    end
endmodule

// File: rtl/dafir_table.sv
// Coefficient partial-sum table built at elaboration; variant picked by CODING
module dafir_table
    import dafir_pkg::*;
#(
    parameter int                TAPS   = 4,
    parameter int                CW     = 8,
    parameter int                TW     = 11,
    parameter da_code_e          CODING = CODE_OFFSET,
    parameter logic [TAPS*CW-1:0] COEFS = '0
) (
    input  logic [TAPS-1:0]        addr_i,
    output logic signed [TW-1:0]   val_o
);
    function automatic int coef(input int k);
        return int'($signed(COEFS[k*CW +: CW]));
    endfunction

    // Plain entry: sum of coefficients whose address bit is 1
    function automatic logic signed [TW-1:0] plain_entry(input int a);
        int s = 0;
        for (int k = 0; k < TAPS; k++)
            if (((a >> k) & 1) == 1) s += coef(k);
        return TW'(s);
    endfunction

    // Half entry: top tap counted +1, the rest +1/-1 by address bit
    function automatic logic signed [TW-1:0] half_entry(input int a);
        int s = coef(TAPS - 1);
        for (int k = 0; k < TAPS - 1; k++)
            s += (((a >> k) & 1) == 1) ? coef(k) : -coef(k);
        return TW'(s);
    endfunction

    if (CODING == CODE_TWOS) begin : g_plain
        localparam int ENTRIES = 1 << TAPS;
        logic signed [TW-1:0] rom [ENTRIES];
        for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
            assign rom[i] = plain_entry(i);
        end
        assign val_o = rom[addr_i];
    end else begin : g_half
        localparam int ENTRIES = 1 << (TAPS - 1);
        logic signed [TW-1:0] rom [ENTRIES];
        logic [TAPS-2:0]      idx;
        for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
            assign rom[i] = half_entry(i);
        end
        always_comb begin
            if (addr_i[TAPS-1]) begin
                idx   = addr_i[TAPS-2:0];
                val_o = rom[idx];
            end else begin
                idx   = ~addr_i[TAPS-2:0];
                val_o = -rom[idx];
            end
        end
    end
endmodule

// File: rtl/dafir_fir.sv
// Top: multiplier-free dot product by bit-serial table lookup and shift-accumulate
module dafir_fir
    import dafir_pkg::*;
#(
    parameter int                 TAPS   = 4,
    parameter int                 DW     = 8,
    parameter int                 CW     = 8,
    parameter da_code_e           CODING = CODE_OFFSET,
    parameter logic [TAPS*CW-1:0] COEFS  = {8'h80, 8'h7F, 8'hA6, 8'h25},
    localparam int                TW     = CW + $clog2(TAPS) + 1,
    localparam int                AW     = TW + DW + 1,
    localparam int                RW     = CW + DW + $clog2(TAPS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [TAPS*DW-1:0] taps_i,
    output logic [RW-1:0]      result_o,
    output logic               done_o
);
    function automatic int coef_sum();
        int s = 0;
        for (int k = 0; k < TAPS; k++) s += int'($signed(COEFS[k*CW +: CW]));
        return s;
    endfunction

    // Initial condition: cancels the offset-binary bias after DW halvings
    localparam logic signed [AW-1:0] IC =
        (CODING == CODE_OFFSET) ? AW'(-coef_sum() * (2 ** DW)) : '0;

    typedef struct packed {
        logic signed [AW-1:0] acc;
        logic [RW-1:0]        res;
        logic                 done;
    } acc_t;

    acc_t s_d, s_q;

    logic                 load;
    logic                 busy;
    logic                 sign;
    logic [TAPS-1:0]      bits;
    logic signed [TW-1:0] tval;
    logic signed [AW-1:0] step;
    logic signed [AW-1:0] acc_next;

    dafir_seq #(.DW(DW)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .load_o (load),
        .busy_o (busy),
        .sign_o (sign)
    );

    dafir_bits #(.TAPS(TAPS), .DW(DW)) u_bits (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .shift_i(busy),
        .taps_i (taps_i),
        .bits_o (bits)
    );

    dafir_table #(
        .TAPS  (TAPS),
        .CW    (CW),
        .TW    (TW),
        .CODING(CODING),
        .COEFS (COEFS)
    ) u_table (
        .addr_i(bits),
        .val_o (tval)
    );

    always_comb begin
        step     = {{(AW-TW){tval[TW-1]}}, tval} <<< (DW - 1);
        acc_next = (s_q.acc >>> 1) + (sign ? -step : step);

        s_d      = s_q;
        s_d.done = sign;
        if (sign) begin
            if (CODING == CODE_OFFSET) s_d.res = RW'(acc_next >>> 1);
            else                       s_d.res = RW'(acc_next);
        end
        if (load)      s_d.acc = IC;
        else if (busy) s_d.acc = acc_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign result_o = s_q.res;
    assign done_o   = s_q.done;
endmodule

// File: rtl/dafir_fir_chk.sv
// Temporal checks for dafir_fir, attached by bind
module dafir_fir_chk #(
    parameter int DW = 8,
    parameter int RW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic [RW-1:0] result,
    input logic          busy,
    input logic          sign
);
    localparam int RUNW = $clog2(DW) + 1;

    // Independent count of bit cycles within one computation
    logic [RUNW-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run_q <= '0;
        else if (!busy)     run_q <= '0;
        else if (sign)      run_q <= '0;
        else                run_q <= run_q + 1'b1;
    end

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sign |=> done);

    p_done_needs_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(sign));

    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    p_run_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sign |-> (run_q == RUNW'(DW - 1)));
endmodule

bind dafir_fir dafir_fir_chk #(.DW(DW), .RW(RW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .done  (done_o),
    .result(result_o),
    .busy  (busy),
    .sign  (sign)
);

// File: tb/test_dafir_fir.sv
module test_dafir_fir;
    import dafir_pkg::*;

    localparam int TAPS = 4;
    localparam int DW   = 8;
    localparam int CW   = 8;
    localparam int RW   = CW + DW + $clog2(TAPS);
    localparam logic [TAPS*CW-1:0] CO = {8'h80, 8'h7F, 8'hA6, 8'h25};
    localparam int C0 = 37, C1 = -90, C2 = 127, C3 = -128;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [TAPS*DW-1:0] taps = '0;
    logic [RW-1:0]      res_off, res_two;
    logic               done_off, done_two;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    dafir_fir #(.TAPS(TAPS), .DW(DW), .CW(CW), .CODING(CODE_OFFSET), .COEFS(CO)) i_dafir_fir (
        .clk(clk), .rst_n(rst_n), .start_i(start), .taps_i(taps),
        .result_o(res_off), .done_o(done_off));

    dafir_fir #(.TAPS(TAPS), .DW(DW), .CW(CW), .CODING(CODE_TWOS), .COEFS(CO)) i_dafir_fir_twos (
        .clk(clk), .rst_n(rst_n), .start_i(start), .taps_i(taps),
        .result_o(res_two), .done_o(done_two));

    function automatic int dot(input logic [TAPS*DW-1:0] w);
        return C0 * int'($signed(w[0 +: DW])) + C1 * int'($signed(w[DW +: DW]))
             + C2 * int'($signed(w[2*DW +: DW])) + C3 * int'($signed(w[3*DW +: DW]));
    endfunction

    function automatic logic [TAPS*DW-1:0] pack(input int a, input int b, input int c, input int d);
        return {DW'(d), DW'(c), DW'(b), DW'(a)};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Check the result in both codings; R8 compares the two
    task automatic chk_result(input string req, input int exp);
        chk(int'($signed(res_off)) == exp, req, int'($signed(res_off)), exp);
        chk(int'($signed(res_two)) == exp, {req, "/R8"}, int'($signed(res_two)), exp);
    endtask

    // Drive a start; returns at the negedge after the accepting edge
    task automatic launch(input logic [TAPS*DW-1:0] w);
        @(negedge clk);
        taps  = w;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        taps  = '0;
    endtask

    // From the negedge after the accepting edge: done low through edge DW-1, high after DW
    task automatic await_result(input string req, input int exp);
        repeat (DW - 1) @(posedge clk);
        @(negedge clk);
        chk(!done_off && !done_two, "R4 early", int'(done_off), 0);
        @(posedge clk);
        @(negedge clk);
        chk(done_off && done_two, "R4 due", int'(done_off), 1);
        chk_result(req, exp);
    endtask

    task automatic t_reset();
        chk(done_off == 1'b0 && done_two == 1'b0, "R1 done", int'(done_off), 0);
        chk(res_off == '0 && res_two == '0, "R1 result", int'($signed(res_off)), 0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(done_off == 1'b0, "R1 done idle", int'(done_off), 0);
        chk(res_off == '0, "R1 result idle", int'($signed(res_off)), 0);
    endtask

    task automatic t_random();
        for (int i = 0; i < 24; i++) begin
            logic [TAPS*DW-1:0] w = TAPS*DW'($urandom);
            launch(w);
            await_result("R2 random", dot(w));
        end
    endtask

    task automatic t_extremes();
        logic [TAPS*DW-1:0] w;
        w = pack(-128, -128, -128, -128); launch(w); await_result("R3 all min", dot(w));
        w = pack(127, 127, 127, 127);     launch(w); await_result("R3 all max", dot(w));
        w = pack(0, 0, 0, 0);             launch(w); await_result("R3 zero", dot(w));
        w = pack(-128, 127, -128, 127);   launch(w); await_result("R3 mixed", dot(w));
        w = pack(-1, 1, -1, 1);           launch(w); await_result("R2 small", dot(w));
    endtask

    task automatic t_busy_start();
        logic [TAPS*DW-1:0] a = pack(100, -7, 55, -128);
        int ea = dot(a);
        launch(a);
        repeat (2) @(posedge clk);
        @(negedge clk);
        start = 1'b1;
        taps  = pack(-128, -128, 127, 3);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        taps  = '0;
        // accepting edge was E0; now past E3
        repeat (DW - 4) @(posedge clk);
        @(negedge clk);
        chk(!done_off, "R5 no early done", int'(done_off), 0);
        @(posedge clk);
        @(negedge clk);
        chk(done_off && done_two, "R5 on time", int'(done_off), 1);
        chk_result("R5 first result kept", ea);
        for (int i = 0; i < DW + 2; i++) begin
            @(negedge clk);
            chk(!done_off && !done_two, "R5 no extra done", int'(done_off), 0);
            chk(int'($signed(res_off)) == ea, "R7 hold", int'($signed(res_off)), ea);
        end
    endtask

    task automatic t_back_to_back();
        logic [TAPS*DW-1:0] a = pack(-128, 90, -3, 77);
        logic [TAPS*DW-1:0] b = pack(127, -128, 64, -64);
        launch(a);
        repeat (DW - 1) @(posedge clk);
        @(negedge clk);
        chk(!done_off, "R6 early", int'(done_off), 0);
        start = 1'b1;
        taps  = b;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        taps  = '0;
        chk(done_off && done_two, "R6 first done", int'(done_off), 1);
        chk_result("R6 first", dot(a));
        await_result("R6 second", dot(b));
    endtask

    initial begin
        t_reset();
        t_random();
        t_extremes();
        t_busy_start();
        t_back_to_back();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule